// File: doc/BRIEF.md
# Paged EEPROM Write Loader

This block is a clocked model of the write side of a byte-wide parallel EEPROM. It watches the active-low chip-select, read-enable and write-strobe pins. It also watches an address bus and a data bus. Each valid write strobe is turned into a byte load. Loads gather into a page buffer that holds one data byte and one "loaded" flag per byte slot.

A load timer runs while the page is open, and every accepted load restarts it. When the timer expires, the page closes and a fixed-length programming period starts, with `busy` high. On the last cycle of that period, only the flagged bytes are written into the array model. A plain read port returns the stored byte one clock after the address is presented. System software uses the block by strobing in up to a full page of bytes, then polling `busy`.

The array depth is set by `ADDR_W`. The default is kept small so that the model stays light. The page size is 64 bytes.

Top module: `eeprom_page_loader`

## Requirements
- R1: A byte load is recognised when the write strobe and the chip select are both low together while the read enable is high. It does not matter which of the two strobes falls first or rises first.
- R2: No load occurs while the read enable is low, while the chip select stays high, or while the write strobe stays high.
- R3: The address is taken when the last of chip select and write strobe falls. The data is taken when the first of the two rises.
- R4: A combined strobe low period shorter than `MIN_PULSE` clock cycles (after synchronisation) produces no load.
- R5: Every accepted load restarts the load window. Programming starts `T_BLC_CYCLES` cycles after the last accepted load, and `busy` stays low until then.
- R6: `busy` stays high for `T_WC_CYCLES` cycles. The array is updated on the last busy cycle, and `busy` then falls.
- R7: Only the byte slots loaded during the page are written, and all other bytes keep their values. Slots may be loaded in any order. A slot loaded twice keeps the later value.
- R8: Address bits `ADDR_W-1` down to 6 name the page, and bits 5 down to 0 name the byte slot. A load naming a page other than the open one is dropped and sets `page_err`. `page_err` stays set until reset.
- R9: Loads that complete while `busy` is high are dropped and have no effect on the array or on later timing.
- R10: After reset, `busy` and `page_err` are low and every array byte reads 0x00.
- R11: `dout` shows the array byte at `addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address: page in upper bits, slot in the low 6 bits |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, registered |
| busy | output | 1 | High during the programming period |
| page_err | output | 1 | Sticky flag for a load to a foreign page |

## Verification
Each strobe edge passes two synchroniser flops, so a load is accepted three cycles after the strobe releases. Programming begins `T_BLC_CYCLES` cycles later, and the array and `busy` change `T_WC_CYCLES` cycles after that. Read data is due one cycle after the address. The bench drives inputs on falling edges. It checks `busy` at points well inside the open window and well inside the programming period. For the end of programming, it waits for `busy` to fall before reading back. Read data is sampled two falling edges after the address is applied, which is one cycle past the point where it is due.

// File: rtl/eepl_pkg.sv
// Shared types for the paged EEPROM write loader.
package eepl_pkg;
    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_LOAD = 2'd1,
        PG_PROG = 2'd2
    } pg_state_t;
endpackage

// File: rtl/eepl_strobe_sync.sv
// Two-flop synchroniser for a vector of active-low strobes.
// Assumes each bit is an independent slow control; resets to inactive (high).
module eepl_strobe_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_n,
    output logic [W-1:0] sync_n
);
    logic [W-1:0] meta_n;

    // Bring the strobes into the clock domain through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_n <= '1;
            sync_n <= '1;
        end else begin
            meta_n <= async_n;
            sync_n <= meta_n;
        end
    end
endmodule

// File: rtl/eepl_write_detect.sv
// Turns synchronised strobes into single-cycle byte loads.
// The address is taken when the combined write condition starts, which is the
// last of chip select / write strobe falling. The data is taken when it ends,
// which is the first rising. Assumes addr and din are stable around those
// synchronised edges. Pulses shorter than MIN_PULSE cycles are discarded.
module eepl_write_detect #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s_n,
    input  logic              oe_s_n,
    input  logic              we_s_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              load_v,
    output logic [ADDR_W-1:0] load_addr,
    output logic [DATA_W-1:0] load_data,
    output logic              act_q
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);

    logic             act;
    logic [CNT_W-1:0] cnt;

    // Combined write condition: both strobes low with read enable high.
    always_comb act = !ce_s_n && !we_s_n && oe_s_n;

    // Track the pulse, latch the address at its start, emit a load at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q     <= 1'b0;
            cnt       <= '0;
            load_v    <= 1'b0;
            load_addr <= '0;
            load_data <= '0;
        end else begin
            act_q  <= act;
            load_v <= 1'b0;
            if (act && !act_q) begin
                load_addr <= addr;
                cnt       <= CNT_W'(1);
            end else if (act && cnt < CNT_W'(MIN_PULSE)) begin
                cnt <= cnt + CNT_W'(1);
            end
            if (!act && act_q && cnt >= CNT_W'(MIN_PULSE)) begin
                load_v    <= 1'b1;
                load_data <= din;
            end
        end
    end
endmodule

// File: rtl/eepl_page_ctrl.sv
// Page buffer with per-slot load flags, load window timer and program timer.
// Assumes load_v is a single-cycle pulse. Commit is high on the last busy cycle.
module eepl_page_ctrl
    import eepl_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int OFS_W        = 6,
    parameter int T_BLC_CYCLES = 7500,
    parameter int T_WC_CYCLES  = 50000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load_v,
    input  logic [ADDR_W-1:0]                 load_addr,
    input  logic [DATA_W-1:0]                 load_data,
    output logic                              busy,
    output logic                              page_err,
    output logic                              commit,
    output logic [ADDR_W-OFS_W-1:0]           cm_page,
    output logic [(1<<OFS_W)-1:0]             cm_mask,
    output logic [(1<<OFS_W)-1:0][DATA_W-1:0] cm_data
);
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int PAGE_W     = ADDR_W - OFS_W;
    localparam int TMAX       = (T_BLC_CYCLES > T_WC_CYCLES) ? T_BLC_CYCLES : T_WC_CYCLES;
    localparam int TMR_W      = $clog2(TMAX + 1);

    pg_state_t         state;
    logic [TMR_W-1:0]  tmr;
    logic [PAGE_W-1:0] ld_page;
    logic [OFS_W-1:0]  ld_ofs;
    logic              same_pg;

    // Split the load address into page and slot, and compare with the open page.
    always_comb begin
        ld_page = load_addr[ADDR_W-1:OFS_W];
        ld_ofs  = load_addr[OFS_W-1:0];
        same_pg = (ld_page == cm_page);
        busy    = (state == PG_PROG);
        commit  = (state == PG_PROG) && (tmr == TMR_W'(T_WC_CYCLES - 1));
    end

    // Sequence idle, loading and programming, and keep the page, flags and error state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PG_IDLE;
            tmr      <= '0;
            cm_page  <= '0;
            cm_mask  <= '0;
            page_err <= 1'b0;
        end else begin
            case (state)
                PG_IDLE: if (load_v) begin
                    cm_page <= ld_page;
                    cm_mask <= PAGE_BYTES'(1) << ld_ofs;
                    tmr     <= '0;
                    state   <= PG_LOAD;
                end
                PG_LOAD: begin
                    if (load_v && same_pg) begin
                        cm_mask[ld_ofs] <= 1'b1;
                        tmr             <= '0;
                    end else begin
                        if (load_v) page_err <= 1'b1;
                        if (tmr == TMR_W'(T_BLC_CYCLES - 1)) begin
                            tmr   <= '0;
                            state <= PG_PROG;
                        end else begin
                            tmr <= tmr + TMR_W'(1);
                        end
                    end
                end
                PG_PROG: begin
                    if (commit) begin
                        tmr   <= '0;
                        state <= PG_IDLE;
                    end else begin
                        tmr <= tmr + TMR_W'(1);
                    end
                end
                default: state <= PG_IDLE;
            endcase
        end
    end

    // Store the byte of each accepted load in its slot (data path, no reset needed).
    always_ff @(posedge clk) begin
        if ((state == PG_IDLE && load_v) || (state == PG_LOAD && load_v && same_pg))
            cm_data[ld_ofs] <= load_data;
    end
endmodule

// File: rtl/eepl_array.sv
// Byte array model: clears on reset, writes flagged slots of one page on commit,
// and reads through a one-cycle registered port.
module eepl_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [ADDR_W-OFS_W-1:0]           cm_page,
    input  logic [(1<<OFS_W)-1:0]             cm_mask,
    input  logic [(1<<OFS_W)-1:0][DATA_W-1:0] cm_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 dout
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << OFS_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, commit flagged slots, register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            dout <= '0;
        end else begin
            dout <= mem[rd_addr];
            if (commit) begin
                for (int i = 0; i < PAGE_BYTES; i++)
                    if (cm_mask[i]) mem[{cm_page, OFS_W'(i)}] <= cm_data[i];
            end
        end
    end
endmodule

// File: rtl/eeprom_page_loader.sv
// Top of the paged EEPROM write loader: synchroniser, write detector,
// page controller and array. Assumes addr/din are held stable around strobe edges.
module eeprom_page_loader #(
    parameter int ADDR_W       = 11,
    parameter int T_BLC_CYCLES = 7500,
    parameter int T_WC_CYCLES  = 50000,
    parameter int MIN_PULSE    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              busy,
    output logic              page_err
);
    localparam int DATA_W     = 8;
    localparam int OFS_W      = 6;
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int PAGE_W     = ADDR_W - OFS_W;

    logic [2:0]                        strb_s_n;
    logic                              load_v;
    logic [ADDR_W-1:0]                 load_addr;
    logic [DATA_W-1:0]                 load_data;
    logic                              act_q;
    logic                              commit;
    logic [PAGE_W-1:0]                 cm_page;
    logic [PAGE_BYTES-1:0]             cm_mask;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] cm_data;

    eepl_strobe_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_n({ce_n, oe_n, we_n}), .sync_n(strb_s_n)
    );

    eepl_write_detect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_det (
        .clk(clk), .rst_n(rst_n),
        .ce_s_n(strb_s_n[2]), .oe_s_n(strb_s_n[1]), .we_s_n(strb_s_n[0]),
        .addr(addr), .din(din),
        .load_v(load_v), .load_addr(load_addr), .load_data(load_data), .act_q(act_q)
    );

    eepl_page_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W),
        .T_BLC_CYCLES(T_BLC_CYCLES), .T_WC_CYCLES(T_WC_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .load_v(load_v), .load_addr(load_addr), .load_data(load_data),
        .busy(busy), .page_err(page_err), .commit(commit),
        .cm_page(cm_page), .cm_mask(cm_mask), .cm_data(cm_data)
    );

    eepl_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .cm_page(cm_page), .cm_mask(cm_mask), .cm_data(cm_data),
        .rd_addr(addr), .dout(dout)
    );
endmodule

// File: rtl/eeprom_page_loader_chk.sv
// Property checker for the paged EEPROM write loader, bound to the top module.
// Relates the busy flag, the commit strobe, the error flag and the load pulse over time.
module eeprom_page_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic page_err,
    input logic load_v,
    input logic act_q,
    input logic commit
);
    // R8: once set, the error flag holds until reset.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err);

    // R8: the error flag only rises in response to a load.
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_err) |-> $past(load_v));

    // R6: busy holds until the commit cycle.
    a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> busy);

    // R6: the commit only happens during the programming period.
    a_r6_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);

    // R6: busy only falls right after a commit.
    a_r6_fall_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(commit));

    // R1: a load follows the end of a combined strobe pulse.
    a_r1_load_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        load_v |-> (!act_q && $past(act_q)));
endmodule

bind eeprom_page_loader eeprom_page_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .page_err(page_err),
    .load_v(load_v), .act_q(act_q), .commit(commit)
);

// File: tb/eeprom_page_loader_bench.sv
module eeprom_page_loader_bench;
    localparam int ADDR_W = 11;
    localparam int T_BLC  = 40;
    localparam int T_WC   = 120;
    localparam int MINP   = 3;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic              busy, page_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] ref_mem [DEPTH];

    always #10 clk = ~clk;

    eeprom_page_loader #(
        .ADDR_W(ADDR_W), .T_BLC_CYCLES(T_BLC), .T_WC_CYCLES(T_WC), .MIN_PULSE(MINP)
    ) u_eeprom_page_loader (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .busy(busy), .page_err(page_err)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int aidx(input int pg, input int ofs);
        return pg * 64 + ofs;
    endfunction

    // Write-strobe controlled load: chip select low first, write strobe pulsed.
    task automatic we_write(input int a, input int d, input int low_cyc);
        addr = ADDR_W'(a); din = 8'(d); oe_n = 1'b1; ce_n = 1'b0;
        tick(1);
        we_n = 1'b0;
        tick(low_cyc);
        we_n = 1'b1;
        tick(4);
        ce_n = 1'b1;
        tick(1);
    endtask

    task automatic rd_chk(input string req, input int a);
        addr = ADDR_W'(a); oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b1;
        tick(2);
        chk(req, int'(dout), int'(ref_mem[a]));
        oe_n = 1'b1; ce_n = 1'b1;
        tick(1);
    endtask

    // Wait out the load window, confirm busy, then wait for programming to end.
    task automatic finish_prog(input string req);
        tick(T_BLC + 6);
        chk(req, int'(busy), 1);
        for (int i = 0; i < T_WC + 20 && busy; i++) tick(1);
        chk("R6 busy ends", int'(busy), 0);
        tick(2);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R10: reset state.
        chk("R10 busy", int'(busy), 0);
        chk("R10 page_err", int'(page_err), 0);
        rd_chk("R10 array clear", aidx(0, 0));
        rd_chk("R10 array clear", aidx(31, 63));

        // R1, R7, R11: out of order, reloaded slot, untouched neighbour.
        we_write(aidx(3, 5), 8'hAA, 5);
        we_write(aidx(3, 2), 8'h11, 5);
        we_write(aidx(3, 5), 8'hBB, 5);
        ref_mem[aidx(3, 5)] = 8'hBB; ref_mem[aidx(3, 2)] = 8'h11;
        finish_prog("R5 busy after window");
        rd_chk("R7 last value wins", aidx(3, 5));
        rd_chk("R7 loaded slot", aidx(3, 2));
        rd_chk("R7 untouched slot", aidx(3, 4));

        // R1, R3: chip-select controlled load; address at last fall, data at first rise.
        addr = ADDR_W'(aidx(4, 9)); din = 8'h00; oe_n = 1'b1; we_n = 1'b0;
        tick(4);
        addr = ADDR_W'(aidx(4, 17)); din = 8'hC3; ce_n = 1'b0;
        tick(5);
        addr = ADDR_W'(aidx(4, 9));
        tick(2);
        ce_n = 1'b1;
        tick(5);
        din = 8'h3C;
        tick(2);
        we_n = 1'b1;
        tick(2);
        ref_mem[aidx(4, 17)] = 8'hC3;
        finish_prog("R1 chip-select write starts programming");
        rd_chk("R3 address and data capture", aidx(4, 17));
        rd_chk("R3 other address untouched", aidx(4, 9));

        // R4: pulse shorter than the minimum is ignored.
        we_write(aidx(5, 1), 8'h99, 1);
        tick(T_BLC + 10);
        chk("R4 short pulse no busy", int'(busy), 0);
        rd_chk("R4 short pulse no write", aidx(5, 1));

        // R2: read enable low or chip select high blocks writes.
        addr = ADDR_W'(aidx(5, 2)); din = 8'h42; ce_n = 1'b0; oe_n = 1'b0;
        tick(1); we_n = 1'b0; tick(6); we_n = 1'b1; tick(3);
        ce_n = 1'b1; oe_n = 1'b1;
        tick(1); we_n = 1'b0; tick(6); we_n = 1'b1; tick(3);
        tick(T_BLC + 10);
        chk("R2 blocked no busy", int'(busy), 0);
        rd_chk("R2 blocked no write", aidx(5, 2));

        // R5: each load restarts the window.
        for (int k = 0; k < 5; k++) begin
            we_write(aidx(6, k * 3), 8'(8'h20 + k), 5);
            ref_mem[aidx(6, k * 3)] = 8'(8'h20 + k);
            tick(18);
            chk("R5 window restarted", int'(busy), 0);
        end
        finish_prog("R5 busy after last load");
        for (int k = 0; k < 5; k++) rd_chk("R5 all loads kept", aidx(6, k * 3));

        // R8: load to another page is dropped and flagged.
        we_write(aidx(7, 1), 8'h71, 5);
        we_write(aidx(8, 1), 8'h81, 5);
        ref_mem[aidx(7, 1)] = 8'h71;
        tick(2);
        chk("R8 page_err set", int'(page_err), 1);
        finish_prog("R8 busy");
        rd_chk("R8 open page written", aidx(7, 1));
        rd_chk("R8 foreign page dropped", aidx(8, 1));
        chk("R8 page_err sticky", int'(page_err), 1);

        // R9: loads during busy are ignored.
        we_write(aidx(9, 0), 8'h5A, 5);
        ref_mem[aidx(9, 0)] = 8'h5A;
        tick(T_BLC + 6);
        chk("R9 busy before load", int'(busy), 1);
        we_write(aidx(9, 1), 8'h77, 5);
        for (int i = 0; i < T_WC + 20 && busy; i++) tick(1);
        tick(T_BLC + 10);
        chk("R9 no new programming", int'(busy), 0);
        rd_chk("R9 first byte written", aidx(9, 0));
        rd_chk("R9 busy load dropped", aidx(9, 1));

        // R7, R5: random pages and slot subsets against the model.
        for (int r = 0; r < 5; r++) begin
            int pg = int'($urandom % 32);
            int nl = 1 + int'($urandom % 8);
            for (int k = 0; k < nl; k++) begin
                int ofs = int'($urandom % 64);
                int d = int'($urandom % 256);
                we_write(aidx(pg, ofs), d, 3 + int'($urandom % 4));
                ref_mem[aidx(pg, ofs)] = 8'(d);
            end
            finish_prog("R5 random busy");
            for (int ofs = 0; ofs < 64; ofs++) rd_chk("R7 random page readback", aidx(pg, ofs));
        end

        done = 1'b1;
        summary();
    end
endmodule